// File: doc/BRIEF.md
# Command-Armed UART Receive Sequencer

This block is the receive half of a serial engine. It ignores the RX line until software writes a start-read opcode into the command register. From then on it watches the line at 32 ticks per bit and builds 8-bit characters: 8 data bits, least significant bit first, with one stop bit and no parity. Each good character goes into a small receive FIFO. Software reads the FIFO through a data register and a word-count register.

Several interrupt sources report progress. One fires when the FIFO reaches a fill level. One fires when the line has been idle for a while after the last character. Two more fire when an abort finishes. The abort is requested through a control bit that clears itself once the sequencer has stopped, so software can poll it. A separate force-default write returns the whole receive path to idle at once.

All register access uses a simple word-addressed read/write port. One access takes one cycle. Register addresses (word index): 0 command, 1 control, 2 interrupt status, 3 interrupt enable, 4 RX data, 5 RX count, 6 engine status, 7 force-default, 8 primary interrupt status.

Top module: `uart_rx_sequencer`

## Requirements
- R1: After reset, the control, interrupt status, RX count and engine status registers all read 0, and `irq` is low.
- R2: A command write whose bits 31:27 hold opcode 1 makes bit 12 of the engine status read 1. A write with any other opcode leaves bit 12 at 0.
- R3: While armed, each 8N1 frame on `rx_line` is stored in the FIFO. A frame is OVS clocks per bit at CLK_DIV=1, LSB first, and each bit is sampled at its middle. The RX count register reports the number of stored words in bits 24:0.
- R4: A frame whose stop bit is sampled low is discarded, and the count does not change.
- R5: A low pulse that has ended before the middle of the start bit is rejected, and no character is stored.
- R6: A read of the RX data register returns the oldest character in bits 7:0 and removes it from the FIFO. A read when the FIFO is empty returns 0 and leaves the count at 0.
- R7: Interrupt status bit 26 is set when a stored character brings the count to WATERMARK or more.
- R8: Interrupt status bit 27 is set STALE_CYCLES clocks after the last stored character, provided no new frame has started. It is not set before then.
- R9: Writing 1 to control bit 1 starts an abort. That bit reads 1 for ABORT_LAT cycles and then returns to 0 by itself. The engine status bit 12 then reads 0, and interrupt status bits 5 and 0 are set.
- R10: Interrupt status bits are cleared by writing 1 to them. `irq` is high exactly when some status bit is set whose enable bit is also set.
- R11: Bit 31 of the primary interrupt status reads 1 when any receive interrupt status bit is set, and reads 0 otherwise.
- R12: Writing 1 to bit 0 of the force-default register empties the FIFO and disarms the engine.
- R13: A character that arrives while the FIFO holds DEPTH words is dropped. The count stays at DEPTH and the oldest word is kept.
- R14: While the engine is not armed, traffic on `rx_line` stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Word address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe (a read of the data register pops the FIFO) |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| rx_line | input | 1 | Serial receive line, idle high |
| irq | output | 1 | Interrupt: any enabled status bit is set |

## Verification
A bit engine that loses its tick count or bit index shows up at the ports within one frame. The character read from the data register comes out shifted, or the frame is discarded as a framing error, so the count stays at 0. A FIFO pointer or count that goes wrong shows up at the next read of the count or data register: a wrong word count, a stale character, or a nonzero value from an empty FIFO. An abort or stale timer that fails appears a few cycles or STALE_CYCLES cycles later. The control bit stays stuck at 1, or interrupt status bits 5, 0 or 27 never set.

// File: rtl/uart_rxseq_pkg.sv
package uart_rxseq_pkg;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    // register word addresses
    localparam logic [3:0] A_CMD    = 4'd0;
    localparam logic [3:0] A_CTRL   = 4'd1;
    localparam logic [3:0] A_ISTAT  = 4'd2;
    localparam logic [3:0] A_IEN    = 4'd3;
    localparam logic [3:0] A_RXDATA = 4'd4;
    localparam logic [3:0] A_RXCNT  = 4'd5;
    localparam logic [3:0] A_STATUS = 4'd6;
    localparam logic [3:0] A_FORCE  = 4'd7;
    localparam logic [3:0] A_PSTAT  = 4'd8;

    // field positions that software decodes
    localparam int          OPC_LSB        = 27;
    localparam logic [4:0]  OPC_START_READ = 5'd1;
    localparam int          CTRL_ABORT     = 1;
    localparam int          ST_ACTIVE      = 12;
    localparam int          IRQ_DONE       = 0;
    localparam int          IRQ_ABORT      = 5;
    localparam int          IRQ_WMARK      = 26;
    localparam int          IRQ_LAST       = 27;
    localparam int          PRI_SEC_EVT    = 31;
    localparam int          CNT_FIELD_W    = 25;

endpackage

// File: rtl/rxseq_bit_engine.sv
module rxseq_bit_engine
    import uart_rxseq_pkg::*;
#(
    parameter int OVS     = 32,
    parameter int CLK_DIV = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       line_i,
    output logic       rx_valid_o,
    output logic [7:0] rx_byte_o,
    output logic       busy_o
);
    localparam int TW   = $clog2(OVS);
    localparam int DIVW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    typedef struct packed {
        logic [1:0]   sync;
        logic         prev;
        logic [DIVW-1:0] div;
        logic [TW-1:0]   tcnt;
        logic [2:0]   bidx;
        logic [7:0]   shreg;
        rx_state_e    state;
        logic         valid;
        logic [7:0]   data;
    } eng_s;

    eng_s q, d;
    logic tick;
    logic line;

    assign line = q.sync[1];
    assign tick = (q.div == DIVW'(CLK_DIV - 1));

    always_comb begin
        d       = q;
        d.sync  = {q.sync[0], line_i};
        d.valid = 1'b0;
        d.div   = tick ? '0 : q.div + 1'b1;
        if (!enable) begin
            d.state = RX_IDLE;
            d.prev  = 1'b1;
        end else if (tick) begin
            d.prev = line;
            unique case (q.state)
                RX_IDLE: begin
                    if (q.prev && !line) begin
                        d.state = RX_START;
                        d.tcnt  = '0;
                    end
                end
                RX_START: begin
                    if (q.tcnt == TW'(OVS / 2 - 1)) begin
                        d.tcnt  = '0;
                        d.bidx  = '0;
                        d.state = line ? RX_IDLE : RX_DATA;
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (q.tcnt == TW'(OVS - 1)) begin
                        d.tcnt  = '0;
                        d.shreg = {line, q.shreg[7:1]};
                        if (q.bidx == 3'd7) d.state = RX_STOP;
                        else                d.bidx  = q.bidx + 1'b1;
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (q.tcnt == TW'(OVS - 1)) begin
                        d.tcnt  = '0;
                        d.state = RX_IDLE;
                        if (line) begin
                            d.valid = 1'b1;
                            d.data  = q.shreg;
                        end
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
                default: d.state = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.sync  <= 2'b11;
            q.prev  <= 1'b1;
            q.state <= RX_IDLE;
        end else begin
            q <= d;
        end
    end

    assign rx_valid_o = q.valid;
    assign rx_byte_o  = q.data;
    assign busy_o     = (q.state != RX_IDLE);

    // a character is only delivered out of the stop-bit state (R4)
    p_valid_from_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |-> $past(q.state == RX_STOP));
    // a disarmed engine sits idle (R14)
    p_disarmed_idle_r14: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> q.state == RX_IDLE);

endmodule

// File: rtl/rxseq_fifo.sv
module rxseq_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    input  logic                       flush,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_s;

    fifo_s q, d;
    logic do_push, do_pop;

    assign do_push = push && (q.cnt < CW'(DEPTH));
    assign do_pop  = pop && (q.cnt != '0);

    always_comb begin
        d = q;
        if (do_push) begin
            d.mem[q.wp] = din;
            d.wp = (q.wp == AW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
        end
        if (do_pop) begin
            d.rp = (q.rp == AW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
        end
        d.cnt = q.cnt + CW'(do_push) - CW'(do_pop);
        if (flush) begin
            d.wp  = '0;
            d.rp  = '0;
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dout  = (q.cnt != '0) ? q.mem[q.rp] : '0;
    assign count = q.cnt;

    p_no_overflow_r13: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH));
    p_full_drop_r13: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop && !flush && q.cnt == CW'(DEPTH) |=> q.cnt == CW'(DEPTH));
    p_empty_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop && !push && q.cnt == '0 |=> q.cnt == '0);

endmodule

// File: rtl/uart_rx_sequencer.sv
module uart_rx_sequencer
    import uart_rxseq_pkg::*;
#(
    parameter int OVS          = 32,
    parameter int CLK_DIV      = 1,
    parameter int DEPTH        = 8,
    parameter int WATERMARK    = 2,
    parameter int STALE_CYCLES = 160,
    parameter int ABORT_LAT    = 4,
    parameter int ADDR_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    input  logic              reg_rd,
    output logic [31:0]       reg_rdata,
    input  logic              rx_line,
    output logic              irq
);
    localparam int CW  = $clog2(DEPTH + 1);
    localparam int ABW = $clog2(ABORT_LAT + 1);
    localparam int SW  = $clog2(STALE_CYCLES + 1);

    typedef struct packed {
        logic [31:0]    cmd;
        logic           active;
        logic           abort_pend;
        logic [ABW-1:0] abort_cnt;
        logic [31:0]    istat;
        logic [31:0]    ien;
        logic           stale_arm;
        logic [SW-1:0]  stale_cnt;
    } seq_s;

    seq_s q, d;

    logic          rx_valid, rx_busy;
    logic [7:0]    rx_byte, fifo_dout;
    logic [CW-1:0] fifo_cnt;
    logic          wr_cmd, wr_ctrl, wr_istat, wr_ien, force_def, pop;
    logic [31:0]   set_bits;

    assign wr_cmd    = reg_wr && (4'(reg_addr) == A_CMD);
    assign wr_ctrl   = reg_wr && (4'(reg_addr) == A_CTRL);
    assign wr_istat  = reg_wr && (4'(reg_addr) == A_ISTAT);
    assign wr_ien    = reg_wr && (4'(reg_addr) == A_IEN);
    assign force_def = reg_wr && (4'(reg_addr) == A_FORCE) && reg_wdata[0];
    assign pop       = reg_rd && (4'(reg_addr) == A_RXDATA);

    rxseq_bit_engine #(.OVS(OVS), .CLK_DIV(CLK_DIV)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (q.active),
        .line_i     (rx_line),
        .rx_valid_o (rx_valid),
        .rx_byte_o  (rx_byte),
        .busy_o     (rx_busy)
    );

    rxseq_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_valid),
        .din   (rx_byte),
        .pop   (pop),
        .flush (force_def),
        .dout  (fifo_dout),
        .count (fifo_cnt)
    );

    always_comb begin
        d        = q;
        set_bits = '0;
        if (wr_cmd) begin
            d.cmd = reg_wdata;
            if (reg_wdata[31:OPC_LSB] == OPC_START_READ) d.active = 1'b1;
        end
        if (wr_ien) d.ien = reg_wdata;
        if (q.abort_pend) begin
            if (q.abort_cnt == ABW'(ABORT_LAT - 1)) begin
                d.abort_pend         = 1'b0;
                d.active             = 1'b0;
                set_bits[IRQ_ABORT]  = 1'b1;
                set_bits[IRQ_DONE]   = 1'b1;
            end else begin
                d.abort_cnt = q.abort_cnt + 1'b1;
            end
        end else if (wr_ctrl && reg_wdata[CTRL_ABORT]) begin
            d.abort_pend = 1'b1;
            d.abort_cnt  = '0;
        end
        if (rx_valid && (32'(fifo_cnt) + 1 >= WATERMARK)) set_bits[IRQ_WMARK] = 1'b1;
        if (rx_valid) begin
            d.stale_arm = 1'b1;
            d.stale_cnt = '0;
        end else if (rx_busy) begin
            d.stale_cnt = '0;
        end else if (q.stale_arm) begin
            if (q.stale_cnt == SW'(STALE_CYCLES - 1)) begin
                d.stale_arm        = 1'b0;
                set_bits[IRQ_LAST] = 1'b1;
            end else begin
                d.stale_cnt = q.stale_cnt + 1'b1;
            end
        end
        d.istat = (q.istat & ~(wr_istat ? reg_wdata : 32'h0)) | set_bits;
        if (force_def) begin
            d.active     = 1'b0;
            d.abort_pend = 1'b0;
            d.stale_arm  = 1'b0;
            d.stale_cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (4'(reg_addr))
            A_CMD:    reg_rdata = q.cmd;
            A_CTRL:   reg_rdata[CTRL_ABORT] = q.abort_pend;
            A_ISTAT:  reg_rdata = q.istat;
            A_IEN:    reg_rdata = q.ien;
            A_RXDATA: reg_rdata[7:0] = fifo_dout;
            A_RXCNT:  reg_rdata[CNT_FIELD_W-1:0] = CNT_FIELD_W'(fifo_cnt);
            A_STATUS: reg_rdata[ST_ACTIVE] = q.active;
            A_PSTAT:  reg_rdata[PRI_SEC_EVT] = |q.istat;
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = |(q.istat & q.ien);

    // abort bit stays up until its latency has run (R9)
    p_abort_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q.abort_pend && q.abort_cnt < ABW'(ABORT_LAT - 1) && !force_def |=> q.abort_pend);
    // a finished abort leaves its status flag behind (R9)
    p_abort_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.abort_pend) && !$past(force_def) |-> q.istat[IRQ_ABORT] && q.istat[IRQ_DONE]);
    // a push reaching the threshold raises the watermark flag (R7)
    p_wmark_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && 32'(fifo_cnt) + 1 >= WATERMARK |=> q.istat[IRQ_WMARK]);
    // force-default disarms the engine (R12)
    p_force_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        force_def |=> !q.active && fifo_cnt == '0);

endmodule

// File: tb/uart_rx_sequencer_tb.sv
module uart_rx_sequencer_tb;

    localparam int OVS = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_rdata;
    logic        rx_line = 1'b1;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    uart_rx_sequencer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rd    (reg_rd),
        .reg_rdata (reg_rdata),
        .rx_line   (rx_line),
        .irq       (irq)
    );

    // bit 8 = stop bit level, bits 7:0 = character
    localparam logic [8:0] VEC [0:5] = '{9'h155, 9'h1A3, 9'h100, 9'h1FF, 9'h03C, 9'h180};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, input logic stop);
        logic [9:0] fr;
        fr = {stop, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            rx_line = fr[i];
            repeat (OVS) @(negedge clk);
        end
        rx_line = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'd1, v); check("R1 ctrl", v, 32'h0);
        rd(4'd2, v); check("R1 istat", v, 32'h0);
        rd(4'd5, v); check("R1 count", v, 32'h0);
        rd(4'd6, v); check("R1 status", v, 32'h0);
        check("R1 irq", 32'(irq), 32'h0);

        // R14 not armed: nothing stored
        send(8'h5A, 1'b1);
        rd(4'd5, v); check("R14 count while disarmed", v, 32'h0);

        // R2 arming by opcode
        wr(4'd0, 32'h1000_0000);
        rd(4'd6, v); check("R2 other opcode", v[12], 1'b0);
        wr(4'd0, 32'h0800_0000);
        rd(4'd6, v); check("R2 start-read opcode", v[12], 1'b1);

        // R3 / R4 table of frames
        for (int i = 0; i < 6; i++) begin
            send(VEC[i][7:0], VEC[i][8]);
            rd(4'd5, v); check(VEC[i][8] ? "R3 count" : "R4 framing count", v, VEC[i][8] ? 32'd1 : 32'd0);
            if (VEC[i][8]) begin
                rd(4'd4, v); check("R3 data", v, {24'h0, VEC[i][7:0]});
                rd(4'd5, v); check("R6 count after pop", v, 32'd0);
            end
        end

        // R6 empty read
        rd(4'd4, v); check("R6 empty data", v, 32'h0);
        rd(4'd5, v); check("R6 empty count", v, 32'h0);

        // R5 short glitch
        rx_line = 1'b0;
        repeat (8) @(negedge clk);
        rx_line = 1'b1;
        repeat (400) @(negedge clk);
        rd(4'd5, v); check("R5 glitch count", v, 32'h0);

        // R7 watermark, R8 not yet stale
        wr(4'd2, 32'hFFFF_FFFF);
        send(8'h11, 1'b1);
        rd(4'd2, v); check("R7 below watermark", v[26], 1'b0);
        check("R8 not stale yet", v[27], 1'b0);
        send(8'h22, 1'b1);
        rd(4'd2, v); check("R7 at watermark", v[26], 1'b1);
        rd(4'd5, v); check("R7 count", v, 32'd2);

        // R10 enable and W1C
        wr(4'd3, 32'h0400_0000);
        @(negedge clk); #1 check("R10 irq on", 32'(irq), 32'h1);
        wr(4'd2, 32'h0400_0000);
        rd(4'd2, v); check("R10 w1c bit26", v[26], 1'b0);
        @(negedge clk); #1 check("R10 irq off", 32'(irq), 32'h0);

        // R8 stale, R11 primary mirror
        repeat (200) @(negedge clk);
        rd(4'd2, v); check("R8 stale flag", v[27], 1'b1);
        rd(4'd8, v); check("R11 mirror set", v[31], 1'b1);
        wr(4'd2, 32'hFFFF_FFFF);
        rd(4'd2, v); check("R10 all cleared", v, 32'h0);
        rd(4'd8, v); check("R11 mirror clear", v[31], 1'b0);

        // R12 force default
        wr(4'd7, 32'h1);
        rd(4'd5, v); check("R12 flushed", v, 32'h0);
        rd(4'd6, v); check("R12 disarmed", v[12], 1'b0);
        send(8'h77, 1'b1);
        rd(4'd5, v); check("R12 no store after force", v, 32'h0);

        // R13 overflow drop
        wr(4'd0, 32'h0800_0000);
        for (int i = 0; i < 9; i++) send(8'h30 + 8'(i), 1'b1);
        rd(4'd5, v); check("R13 count full", v, 32'd8);
        rd(4'd4, v); check("R13 oldest kept", v, 32'h30);

        // R9 abort
        wr(4'd2, 32'hFFFF_FFFF);
        wr(4'd1, 32'h2);
        rd(4'd1, v); check("R9 abort pending", v[1], 1'b1);
        repeat (10) @(negedge clk);
        rd(4'd1, v); check("R9 abort self-clear", v[1], 1'b0);
        rd(4'd6, v); check("R9 disarmed", v[12], 1'b0);
        rd(4'd2, v); check("R9 abort+done flags", v & 32'h21, 32'h21);

        finish_run();
    end

endmodule